// File: doc/BRIEF.md
# Four-Cell Logic Cluster with Carry and Cascade

This block is a cluster of four identical logic cells for a reconfigurable fabric. Each cell holds a 16-entry lookup table that is addressed by four of its inputs, a dedicated carry stage, a cascade gate and one storage element. The storage element can be set up as an edge-triggered flip-flop or as a level-sensitive latch. A fifth input per cell, the direct input, can feed the storage element without passing through the lookup table. Each cell drives three outputs: the raw lookup-table value, the value after the cascade gate, and the stored value.

The carry stages run from cell 0 to cell 3, so the cluster can act as a 4-bit adder or counter slice. The cascade gates, each set to AND or OR, merge the cell results into one wide decode term, and that term leaves the cluster on a cascade output. All four cells share one clock, one clock enable and one active-low asynchronous clear. The setup of the whole cluster is loaded through a one-bit serial shift port.

Top module: `logic_cluster4`

## Requirements
- R1: While rst_ni is low, every q_o bit is 0 at once, whatever the clocks, the clock enable and the data are. The configuration register is also cleared to all zeros.
- R2: On each rising clk_i edge with cfg_en_i high, cfg_d_i enters configuration bit 0 and every other bit moves up one place. The register is 85 bits wide. Cell k owns bits 21k+20 down to 21k, laid out as: table at offsets 15..0, carry mode at 16, cascade enable at 17, cascade OR select at 18 (0 selects AND), direct-input select at 19 and latch mode at 20. Bit 84 routes casc_i to cell 0. With cfg_en_i low the configuration does not change.
- R3: When a cell is not in carry mode, lut_o[k] equals the table bit whose index is lut_in_i[4k+3:4k], and bit 0 of that field is the index LSB.
- R4: In carry mode the cell's incoming carry takes the place of index bit 2, and its carry out is the majority of index bits 0 and 1 and the incoming carry. A cell not in carry mode passes its incoming carry straight through. Cell 0 receives carry_i, and carry_o is the carry out of cell 3.
- R5: comb_o[k] is the table output ANDed or ORed with the cell's cascade input when cascade is enabled, and equals the table output when it is not. Cell k>0 takes comb_o[k-1] as its cascade input. Cell 0 takes casc_i when bit 84 is set; otherwise it takes 1 for AND and 0 for OR. casc_o equals comb_o[3].
- R6: The storage element of cell k loads di_i[k] when direct-input select is set, and loads comb_o[k] when it is clear.
- R7: In flip-flop mode q_o[k] changes only at a rising clk_i edge where ce_i is high, and holds otherwise.
- R8: In latch mode q_o[k] follows its data while clk_i and ce_i are both high, and holds while clk_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock, also the latch gate |
| rst_ni | input | 1 | Active-low asynchronous clear |
| ce_i | input | 1 | Shared clock enable |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_d_i | input | 1 | Configuration serial data |
| lut_in_i | input | 16 | Four table inputs per cell, cell k at 4k+3:4k |
| di_i | input | 4 | Direct data input per cell |
| carry_i | input | 1 | Carry into cell 0 |
| casc_i | input | 1 | External cascade input to cell 0 |
| lut_o | output | 4 | Raw table output per cell |
| comb_o | output | 4 | Cascade-gated output per cell |
| q_o | output | 4 | Storage output per cell |
| carry_o | output | 1 | Carry out of cell 3 |
| casc_o | output | 1 | Cascade result of cell 3 |

## Verification
The table, carry and cascade results are combinational, so they are due in the same cycle as the inputs. The bench drives the inputs just after a falling edge and compares those results one time step later, while the clock is still low. Flip-flop results are due at the next rising edge, so they are compared at the following falling edge against a model that updates once per cycle. Two results fall outside that grid. Latch transparency is probed inside the high phase, one step after a data change. The asynchronous clear is probed one step after rst_ni falls, with no clock edge in between.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LUT_IN = 4;
  localparam int LUT_W  = 1 << LUT_IN;

  typedef struct packed {
    logic             latch;
    logic             use_di;
    logic             casc_or;
    logic             casc_en;
    logic             carry_en;
    logic [LUT_W-1:0] table_bits;
  } cell_cfg_t;

  localparam int CELL_CFG_W = $bits(cell_cfg_t);
  localparam int OFS_CARRY  = LUT_W;
  localparam int OFS_CASC   = LUT_W + 1;
  localparam int OFS_OR     = LUT_W + 2;
  localparam int OFS_DI     = LUT_W + 3;
  localparam int OFS_LATCH  = LUT_W + 4;
endpackage

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
  parameter int W = 85
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= {q_o[W-2:0], d_i};
  end
endmodule

// File: rtl/lc_cell.sv
module lc_cell
  import lc_pkg::*;
(
  input  cell_cfg_t         cfg_i,
  input  logic [LUT_IN-1:0] lin_i,
  input  logic              cy_i,
  input  logic              cs_i,
  output logic              f_o,
  output logic              x_o,
  output logic              cy_o
);
  logic [LUT_IN-1:0] idx;
  logic              op_a, op_b;

  assign op_a = lin_i[0];
  assign op_b = lin_i[1];

  // carry mode: incoming carry takes index bit 2
  always_comb begin
    idx = lin_i;
    if (cfg_i.carry_en) idx[2] = cy_i;
  end

  assign f_o  = cfg_i.table_bits[idx];
  assign cy_o = cfg_i.carry_en ? ((op_a & op_b) | (cy_i & (op_a ^ op_b))) : cy_i;

  always_comb begin
    if (!cfg_i.casc_en)     x_o = f_o;
    else if (cfg_i.casc_or) x_o = f_o | cs_i;
    else                    x_o = f_o & cs_i;
  end
endmodule

// File: rtl/lc_store.sv
module lc_store (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic latch_i,
  input  logic d_i,
  output logic q_o
);
  logic ff_q, lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ff_q <= 1'b0;
    else if (ce_i && !latch_i)   ff_q <= d_i;
  end

  // transparent while clock high
  always_latch begin
    if (!rst_ni)                         lat_q = 1'b0;
    else if (clk_i && ce_i && latch_i)   lat_q = d_i;
  end

  assign q_o = latch_i ? lat_q : ff_q;
endmodule

// File: rtl/logic_cluster4.sv
module logic_cluster4
  import lc_pkg::*;
#(
  parameter int N_CELLS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ce_i,
  input  logic                     cfg_en_i,
  input  logic                     cfg_d_i,
  input  logic [N_CELLS*LUT_IN-1:0] lut_in_i,
  input  logic [N_CELLS-1:0]       di_i,
  input  logic                     carry_i,
  input  logic                     casc_i,
  output logic [N_CELLS-1:0]       lut_o,
  output logic [N_CELLS-1:0]       comb_o,
  output logic [N_CELLS-1:0]       q_o,
  output logic                     carry_o,
  output logic                     casc_o
);
  localparam int CFG_W   = N_CELLS * CELL_CFG_W + 1;
  localparam int EXT_BIT = CFG_W - 1;

  logic [CFG_W-1:0]   cfg_q;
  cell_cfg_t          cell_cfg [N_CELLS];
  logic [N_CELLS:0]   cy, cs;
  logic [N_CELLS-1:0] d_sel;

  lc_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg_en_i),
    .d_i   (cfg_d_i),
    .q_o   (cfg_q)
  );

  assign cy[0] = carry_i;

  generate
    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
      assign cell_cfg[k] = cell_cfg_t'(cfg_q[k*CELL_CFG_W +: CELL_CFG_W]);

      if (k == 0) begin : g_head
        // identity of the gate unless routed from outside
        assign cs[0] = cfg_q[EXT_BIT] ? casc_i : ~cell_cfg[0].casc_or;
      end

      lc_cell u_cell (
        .cfg_i(cell_cfg[k]),
        .lin_i(lut_in_i[k*LUT_IN +: LUT_IN]),
        .cy_i (cy[k]),
        .cs_i (cs[k]),
        .f_o  (lut_o[k]),
        .x_o  (cs[k+1]),
        .cy_o (cy[k+1])
      );

      assign comb_o[k] = cs[k+1];
      assign d_sel[k]  = cell_cfg[k].use_di ? di_i[k] : cs[k+1];

      lc_store u_store (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ce_i   (ce_i),
        .latch_i(cell_cfg[k].latch),
        .d_i    (d_sel[k]),
        .q_o    (q_o[k])
      );
    end
  endgenerate

  assign carry_o = cy[N_CELLS];
  assign casc_o  = cs[N_CELLS];
endmodule

// File: rtl/lc_chk.sv
module lc_chk
  import lc_pkg::*;
#(
  parameter int N_CELLS = 4,
  parameter int CFG_W   = 85
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ce_i,
  input logic               cfg_en_i,
  input logic               carry_i,
  input logic               carry_o,
  input logic               casc_o,
  input logic [N_CELLS-1:0] lut_o,
  input logic [N_CELLS-1:0] q_o,
  input logic [CFG_W-1:0]   cfg_i
);
  localparam int LAST = N_CELLS - 1;
  localparam int LB   = LAST * CELL_CFG_W;

  logic any_carry;
  always_comb begin
    any_carry = 1'b0;
    for (int k = 0; k < N_CELLS; k++) any_carry |= cfg_i[k*CELL_CFG_W + OFS_CARRY];
  end

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) clear_zero_chk: assert (q_o == '0);
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_i));

  // R7
  q_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(q_o));

  // R4
  carry_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_carry |-> (carry_o == carry_i));

  // R5
  casc_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[LB + OFS_CASC] && !cfg_i[LB + OFS_OR] && casc_o) |-> lut_o[LAST]);

  // R5
  casc_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[LB + OFS_CASC] && cfg_i[LB + OFS_OR] && lut_o[LAST]) |-> casc_o);
endmodule

bind logic_cluster4 lc_chk #(.N_CELLS(N_CELLS), .CFG_W(CFG_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ce_i    (ce_i),
  .cfg_en_i(cfg_en_i),
  .carry_i (carry_i),
  .carry_o (carry_o),
  .casc_o  (casc_o),
  .lut_o   (lut_o),
  .q_o     (q_o),
  .cfg_i   (cfg_q)
);

// File: tb/logic_cluster4_test.sv
module logic_cluster4_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int CW = 21;
  localparam int VW = NC * CW + 1;

  logic clk = 1'b0, rst_ni = 1'b1, ce = 1'b0, cfg_en = 1'b0, cfg_d = 1'b0;
  logic [15:0] lin = '0;
  logic [3:0]  di = '0;
  logic        cin = 1'b0, cas = 1'b0;
  logic [3:0]  lut_o, comb_o, q_o;
  logic        carry_o, casc_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side configuration
  logic [15:0] m_lut [NC];
  logic        m_cy [NC], m_cs [NC], m_or [NC], m_di [NC], m_lt [NC];
  logic        m_ext;
  logic [3:0]  q_m;
  logic [3:0]  e_f, e_x;
  logic        e_cy, e_cs;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_cluster4 uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce), .cfg_en_i(cfg_en), .cfg_d_i(cfg_d),
    .lut_in_i(lin), .di_i(di), .carry_i(cin), .casc_i(cas),
    .lut_o(lut_o), .comb_o(comb_o), .q_o(q_o), .carry_o(carry_o), .casc_o(casc_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural model of the combinational results
  task automatic calc();
    logic c, s;
    int idx;
    c = cin;
    s = m_ext ? cas : ~m_or[0];
    for (int k = 0; k < NC; k++) begin
      idx = int'(lin[4*k +: 4]);
      if (m_cy[k]) idx = (idx & 11) | (int'(c) << 2);
      e_f[k] = m_lut[k][idx];
      if (m_cy[k]) c = (lin[4*k] + lin[4*k+1] + c) >= 2;
      if (!m_cs[k]) s = e_f[k];
      else if (m_or[k]) s = e_f[k] | s;
      else s = e_f[k] & s;
      e_x[k] = s;
    end
    e_cy = c;
    e_cs = s;
  endtask

  task automatic clear_cfg();
    for (int k = 0; k < NC; k++) begin
      m_lut[k] = '0; m_cy[k] = 0; m_cs[k] = 0; m_or[k] = 0; m_di[k] = 0; m_lt[k] = 0;
    end
    m_ext = 0;
  endtask

  // starts and ends just after a falling edge
  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    chk("R1 clear q", q_o, 4'h0);
    @(negedge clk); #1;
    rst_ni = 1'b1;
    q_m = '0;
  endtask

  task automatic load_cfg();
    logic [VW-1:0] v;
    v = '0;
    v[VW-1] = m_ext;
    for (int k = 0; k < NC; k++) begin
      v[k*CW +: 16] = m_lut[k];
      v[k*CW + 16] = m_cy[k];
      v[k*CW + 17] = m_cs[k];
      v[k*CW + 18] = m_or[k];
      v[k*CW + 19] = m_di[k];
      v[k*CW + 20] = m_lt[k];
    end
    ce = 1'b0;
    for (int i = VW - 1; i >= 0; i--) begin
      cfg_en = 1'b1;
      cfg_d  = v[i];
      @(negedge clk); #1;
    end
    cfg_en = 1'b0;
    chk("R7 hold during load", q_o, q_m);
  endtask

  task automatic cyc(input logic [15:0] l, input logic [3:0] d, input logic c,
                     input logic cs, input logic e, input string tag);
    lin = l; di = d; cin = c; cas = cs; ce = e;
    cfg_d = 1'($urandom);
    calc();
    #1;
    chk({tag, " comb"}, {lut_o, comb_o, carry_o, casc_o}, {e_f, e_x, e_cy, e_cs});
    for (int k = 0; k < NC; k++) if (e) q_m[k] = m_di[k] ? d[k] : e_x[k];
    @(negedge clk);
    chk({tag, " q"}, q_o, q_m);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_cfg();
    #1;
    do_reset();
    cyc(16'hFFFF, 4'hF, 1'b1, 1'b1, 1'b0, "R1 R4 idle");

    // plain tables, flip-flops through LUT / cascade path
    m_lut[0] = 16'h8000; m_lut[1] = 16'hFFFE; m_lut[2] = 16'h6996; m_lut[3] = 16'hCAFE;
    m_di[2] = 1;
    load_cfg();
    for (int i = 0; i < 24; i++)
      cyc(16'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), i % 3 != 0, "R3 R6 R7");
    cyc(16'hFFFF, 4'h0, 1'b0, 1'b0, 1'b1, "R3 all ones");
    cyc(16'h0000, 4'hF, 1'b0, 1'b0, 1'b1, "R6 direct");

    // config shift ignored while enable low: random cfg_d in every cyc
    for (int i = 0; i < 8; i++)
      cyc(16'($urandom), 4'($urandom), 1'b0, 1'b0, 1'b1, "R2 hold");

    // adder
    do_reset(); clear_cfg();
    for (int k = 0; k < NC; k++) begin m_cy[k] = 1; m_lut[k] = 16'h9696; end
    load_cfg();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          logic [15:0] l;
          logic [4:0] sum;
          l = '0;
          for (int k = 0; k < NC; k++) begin l[4*k] = a[k]; l[4*k+1] = b[k]; end
          lin = l; cin = 1'(c); ce = 1'b0;
          sum = 5'(a + b + c);
          #1;
          chk("R4 adder", {carry_o, comb_o}, {sum[4], sum[3:0]});
          @(negedge clk); #1;
        end
    cyc(16'h2323, 4'h0, 1'b1, 1'b0, 1'b1, "R4 model");

    // AND cascade, identity head
    do_reset(); clear_cfg();
    for (int k = 0; k < NC; k++) begin m_cs[k] = 1; m_lut[k] = 16'h8000; end
    load_cfg();
    cyc(16'hFFFF, 4'h0, 1'b0, 1'b0, 1'b1, "R5 and all");
    chk("R5 and all ones", casc_o, 1'b1);
    cyc(16'hFFEF, 4'h0, 1'b0, 1'b1, 1'b1, "R5 and one zero");
    chk("R5 and one zero", casc_o, 1'b0);
    for (int i = 0; i < 8; i++)
      cyc(16'($urandom) | 16'hF7FF, 4'h0, 1'b0, 1'($urandom), 1'b1, "R5 and rnd");

    // OR cascade, external head
    do_reset(); clear_cfg();
    for (int k = 0; k < NC; k++) begin m_cs[k] = 1; m_or[k] = 1; m_lut[k] = 16'hFFFE; end
    m_ext = 1;
    load_cfg();
    cyc(16'h0000, 4'h0, 1'b0, 1'b1, 1'b1, "R5 or ext high");
    chk("R5 or casc_i", casc_o, 1'b1);
    cyc(16'h0000, 4'h0, 1'b0, 1'b0, 1'b1, "R5 or ext low");
    chk("R5 or none", casc_o, 1'b0);
    cyc(16'h0400, 4'h0, 1'b0, 1'b0, 1'b1, "R5 or one");

    // latch mode, direct input
    do_reset(); clear_cfg();
    for (int k = 0; k < NC; k++) begin m_lt[k] = 1; m_di[k] = 1; end
    load_cfg();
    di = 4'b1010; ce = 1'b1;
    @(posedge clk); #1;
    chk("R8 transparent", q_o, 4'b1010);
    di = 4'b0101; #1;
    chk("R8 follows in high", q_o, 4'b0101);
    @(negedge clk); #1;
    di = 4'b1111; #1;
    chk("R8 opaque in low", q_o, 4'b0101);
    q_m = 4'b0101;
    cyc(16'h0, 4'b0011, 1'b0, 1'b0, 1'b1, "R8 cycle");
    cyc(16'h0, 4'b1100, 1'b0, 1'b0, 1'b0, "R8 ce low");

    // flip-flop mode, direct input: edge only
    do_reset(); clear_cfg();
    for (int k = 0; k < NC; k++) m_di[k] = 1;
    m_lut[0] = 16'hFFFF;
    load_cfg();
    di = 4'b1010; ce = 1'b1;
    @(posedge clk); #1;
    chk("R7 capture", q_o, 4'b1010);
    di = 4'b0101; #1;
    chk("R7 no change in high", q_o, 4'b1010);
    @(negedge clk); #1;
    q_m = 4'b1010;
    cyc(16'h0, 4'hF, 1'b0, 1'b0, 1'b1, "R7 load");

    // clear overrides enable, wipes configuration
    ce = 1'b1; di = 4'hF;
    rst_ni = 1'b0; #1;
    chk("R1 async q", q_o, 4'h0);
    chk("R1 cfg wiped", lut_o, 4'h0);
    @(posedge clk); #1;
    chk("R1 over ce", q_o, 4'h0);
    @(negedge clk); #1;
    rst_ni = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule